// File: doc/BRIEF.md
# Saturating Transmit Statistics Counters

This block keeps four small transmit statistics in a single read-only word. A transmit engine reports each finished packet with a one-cycle completion pulse. The pulse carries four things: the number of collisions the packet saw, whether it went out successfully, whether it was deferred, and whether the deferral was excessive. The block sorts that report into four counters. Each counter moves by at most one step per reported packet, so the rate at which the counters can fill is bounded by the packet rate.

The counters stop at their maximum value instead of wrapping. An interrupt request is raised while any counter sits at its maximum.

Software samples the whole word with a read strobe. The strobe returns the current contents in the same cycle and zeroes all four counters at the next clock edge. If a packet report arrives in that same cycle, it is not lost. The affected counters restart at one.

Top module: `txstat_sat_counters`

## Requirements
- R1: After reset the read word is 0x0000 and irq is low. Field positions in the word are: single-collision count in bits 3:0, multiple-collision count in bits 7:4, deferred count in bits 11:8, excessive-deferral count in bits 15:12.
- R2: A counter at 15 stays at 15 on further events and never wraps to 0.
- R3: irq is high exactly while at least one of the four fields equals 15, and low otherwise.
- R4: While rd_stb is high, rd_data shows the contents held before the clear. After that edge, with no event in the same cycle, all fields read 0.
- R5: A completion pulse with pkt_ok=1 and a collision count of exactly 1 adds one to the single-collision field. With pkt_ok=0 the single-collision field is left unchanged.
- R6: A completion pulse with a collision count from 2 to 16 adds one to the multiple-collision field, whatever pkt_ok is. Counts of 0, or 17 and above, leave that field unchanged.
- R7: A completion pulse with pkt_deferred=1 adds exactly one to the deferred field.
- R8: A completion pulse with pkt_exc_deferred=1 adds one to the excessive-deferral field, independently of pkt_deferred.
- R9: No field changes by more than one per completion pulse. Without a pulse or a read, rd_data holds steady.
- R10: If rd_stb and a completion pulse fall in the same cycle, rd_data returns the pre-clear contents. Each counter hit by that pulse then reads 1, and every other counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle completion report for a queued packet |
| pkt_ok | input | 1 | Packet was transmitted successfully |
| pkt_coll_cnt | input | 5 | Collisions suffered by the packet (0 to 31) |
| pkt_deferred | input | 1 | Packet was deferred at least once |
| pkt_exc_deferred | input | 1 | Packet was excessively deferred |
| rd_stb | input | 1 | Read strobe; clears all counters at the clock edge |
| rd_data | output | 16 | Packed counter word |
| irq | output | 1 | High while any counter is saturated |

## Verification
A software read and a packet report can land in the same clock cycle. The read wants every counter at zero, and the report wants some counters one higher. The bench first saturates the single-collision field. It then raises rd_stb together with a completion pulse that carries one collision, a success flag and a deferral. In that cycle the bench expects the saturated word 0x000F. On the following cycle it expects 0x0101 with irq low, which shows that the clear won and the report was still counted from zero. It also checks the plain read without a report, which must leave the word at 0x0000.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

   // Slot order fixes the field position in the packed read word.
   typedef enum int unsigned {
      SLOT_SINGLE = 0,
      SLOT_MULTI  = 1,
      SLOT_DEFER  = 2,
      SLOT_EXCESS = 3
   } txstat_slot_e;

   localparam int unsigned TXSTAT_SLOTS = 4;

   // One decoded packet report, one bit per counter slot.
   typedef struct packed {
      logic excess;
      logic defer;
      logic multi;
      logic single;
   } txstat_bump_t;

endpackage

// File: rtl/txstat_event_decode.sv
module txstat_event_decode
   import txstat_pkg::*;
#(
   parameter int unsigned COLL_W    = 5,
   parameter int unsigned MULTI_MAX = 16
) (
   input  logic              pkt_done,
   input  logic              pkt_ok,
   input  logic [COLL_W-1:0] pkt_coll_cnt,
   input  logic              pkt_deferred,
   input  logic              pkt_exc_deferred,
   output txstat_bump_t      bump
);

   localparam logic [COLL_W-1:0] ONE_COLL  = COLL_W'(1);
   localparam logic [COLL_W-1:0] TWO_COLL  = COLL_W'(2);
   localparam logic [COLL_W-1:0] TOP_COLL  = COLL_W'(MULTI_MAX);

   logic is_single;
   logic is_multi;

   always_comb begin
      is_single = (pkt_coll_cnt == ONE_COLL);
      is_multi  = (pkt_coll_cnt >= TWO_COLL) && (pkt_coll_cnt <= TOP_COLL);
   end

   // Every slot is gated by the single completion pulse, which is what
   // limits each counter to one step per packet.
   always_comb begin
      bump.single = pkt_done & pkt_ok & is_single;
      bump.multi  = pkt_done & is_multi;
      bump.defer  = pkt_done & pkt_deferred;
      bump.excess = pkt_done & pkt_exc_deferred;
   end

endmodule

// File: rtl/txstat_sat_cell.sv
module txstat_sat_cell #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             at_max
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] count_q;

   assign at_max = &count_q;
   assign count  = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= CNT_ZERO;
      end else if (clr) begin
         // Clear wins, but a same-cycle event restarts the count at one.
         count_q <= bump ? CNT_ONE : CNT_ZERO;
      end else if (bump && !at_max) begin
         count_q <= count_q + CNT_ONE;
      end
   end

endmodule

// File: rtl/txstat_sat_counters.sv
module txstat_sat_counters
   import txstat_pkg::*;
#(
   parameter int unsigned CNT_W          = 4,
   parameter int unsigned COLL_W         = 5,
   parameter int unsigned MULTI_MAX      = 16,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pkt_done,
   input  logic                          pkt_ok,
   input  logic [COLL_W-1:0]             pkt_coll_cnt,
   input  logic                          pkt_deferred,
   input  logic                          pkt_exc_deferred,
   input  logic                          rd_stb,
   output logic [TXSTAT_SLOTS*CNT_W-1:0] rd_data,
   output logic                          irq
);

   localparam int unsigned DATA_W = TXSTAT_SLOTS * CNT_W;

   // Elaboration-time parameter checks.
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("txstat_sat_counters: CNT_W must be at least 2");
   end
   if (MULTI_MAX < 2) begin : g_bad_multi_lo
      $error("txstat_sat_counters: MULTI_MAX must be at least 2");
   end
   if (MULTI_MAX >= (1 << COLL_W)) begin : g_bad_multi_hi
      $error("txstat_sat_counters: MULTI_MAX does not fit in COLL_W bits");
   end

   txstat_bump_t              bump;
   logic [TXSTAT_SLOTS-1:0]   bump_vec;
   logic [TXSTAT_SLOTS-1:0]   max_vec;
   logic [DATA_W-1:0]         word;

   txstat_event_decode #(
      .COLL_W    (COLL_W),
      .MULTI_MAX (MULTI_MAX)
   ) u_decode (
      .pkt_done         (pkt_done),
      .pkt_ok           (pkt_ok),
      .pkt_coll_cnt     (pkt_coll_cnt),
      .pkt_deferred     (pkt_deferred),
      .pkt_exc_deferred (pkt_exc_deferred),
      .bump             (bump)
   );

   always_comb begin
      bump_vec[SLOT_SINGLE] = bump.single;
      bump_vec[SLOT_MULTI]  = bump.multi;
      bump_vec[SLOT_DEFER]  = bump.defer;
      bump_vec[SLOT_EXCESS] = bump.excess;
   end

   for (genvar s = 0; s < TXSTAT_SLOTS; s++) begin : g_slot
      txstat_sat_cell #(
         .CNT_W (CNT_W)
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .bump   (bump_vec[s]),
         .clr    (rd_stb),
         .count  (word[s*CNT_W +: CNT_W]),
         .at_max (max_vec[s])
      );
   end

   assign rd_data = word;

   // The interrupt is either taken straight from the saturation flags
   // or retimed through a flop for a cleaner path to the aggregator.
   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= |max_vec;
         end
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |max_vec;
   end

endmodule

// File: rtl/txstat_sat_counters_chk.sv
module txstat_sat_counters_chk #(
   parameter int unsigned CNT_W          = 4,
   parameter int unsigned COLL_W         = 5,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pkt_done,
   input logic                pkt_ok,
   input logic [COLL_W-1:0]   pkt_coll_cnt,
   input logic                pkt_exc_deferred,
   input logic                rd_stb,
   input logic [4*CNT_W-1:0]  rd_data,
   input logic                irq
);

   localparam logic [CNT_W-1:0] FULL = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] fld [4];
   logic             any_full;

   always_comb begin
      for (int k = 0; k < 4; k++) fld[k] = rd_data[k*CNT_W +: CNT_W];
      any_full = (fld[0] == FULL) || (fld[1] == FULL) ||
                 (fld[2] == FULL) || (fld[3] == FULL);
   end

   for (genvar k = 0; k < 4; k++) begin : g_fld
      // R2
      a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
         (fld[k] == FULL && !rd_stb) |=> (fld[k] == FULL));
      // R9
      a_r9_one_step: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> (fld[k] == $past(fld[k]) || fld[k] == $past(fld[k]) + ONE));
      // R10
      a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
         rd_stb |=> (fld[k] <= ONE));
   end

   // R9
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !pkt_done) |=> $stable(rd_data));

   // R4
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !pkt_done) |=> (rd_data == '0));

   // R5
   a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && pkt_ok && pkt_coll_cnt == COLL_W'(1) && !rd_stb && fld[0] != FULL)
      |=> (fld[0] == $past(fld[0]) + ONE));

   // R8
   a_r8_excess: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && pkt_exc_deferred && !rd_stb && fld[3] != FULL)
      |=> (fld[3] == $past(fld[3]) + ONE));

   if (IRQ_REGISTERED) begin : g_irq_reg
      // R3
      a_r3_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
         any_full |=> irq);
   end else begin : g_irq_comb
      // R3
      a_r3_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
         any_full |-> irq);
      // R3
      a_r3_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
         !any_full |-> !irq);
   end

endmodule

bind txstat_sat_counters txstat_sat_counters_chk #(
   .CNT_W          (CNT_W),
   .COLL_W         (COLL_W),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .pkt_done         (pkt_done),
   .pkt_ok           (pkt_ok),
   .pkt_coll_cnt     (pkt_coll_cnt),
   .pkt_exc_deferred (pkt_exc_deferred),
   .rd_stb           (rd_stb),
   .rd_data          (rd_data),
   .irq              (irq)
);

// File: tb/txstat_sat_counters_bench.sv
module txstat_sat_counters_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_done = 1'b0;
   logic        pkt_ok = 1'b0;
   logic [4:0]  pkt_coll_cnt = '0;
   logic        pkt_deferred = 1'b0;
   logic        pkt_exc_deferred = 1'b0;
   logic        rd_stb = 1'b0;
   logic [15:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   txstat_sat_counters u_txstat_sat_counters (
      .clk              (clk),
      .rst_n            (rst_n),
      .pkt_done         (pkt_done),
      .pkt_ok           (pkt_ok),
      .pkt_coll_cnt     (pkt_coll_cnt),
      .pkt_deferred     (pkt_deferred),
      .pkt_exc_deferred (pkt_exc_deferred),
      .rd_stb           (rd_stb),
      .rd_data          (rd_data),
      .irq              (irq)
   );

   // Vector: {coll[4:0], ok, deferred, exc_deferred, expected word[15:0]}
   localparam int NVEC = 9;
   localparam logic [23:0] VEC [NVEC] = '{
      {5'd1,  1'b1, 1'b0, 1'b0, 16'h0001},  // R5 single counted
      {5'd1,  1'b0, 1'b0, 1'b0, 16'h0001},  // R5 failed packet ignored
      {5'd2,  1'b1, 1'b0, 1'b0, 16'h0011},  // R6 lower bound
      {5'd16, 1'b0, 1'b0, 1'b0, 16'h0021},  // R6 upper bound
      {5'd17, 1'b1, 1'b0, 1'b0, 16'h0021},  // R6 beyond range ignored
      {5'd0,  1'b1, 1'b1, 1'b0, 16'h0121},  // R7 deferred once
      {5'd3,  1'b1, 1'b1, 1'b1, 16'h1231},  // R8 with R7 and R6
      {5'd0,  1'b1, 1'b0, 1'b1, 16'h2231},  // R8 alone
      {5'd1,  1'b1, 1'b1, 1'b0, 16'h2332}   // R9 several fields one step
   };

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Drive a one-cycle packet report at a falling edge and release it one cycle later.
   task automatic report(input logic [4:0] coll, input logic ok, input logic dfr, input logic exc);
      @(negedge clk);
      pkt_done = 1'b1; pkt_coll_cnt = coll; pkt_ok = ok;
      pkt_deferred = dfr; pkt_exc_deferred = exc;
      @(negedge clk);
      pkt_done = 1'b0; pkt_coll_cnt = '0; pkt_ok = 1'b0;
      pkt_deferred = 1'b0; pkt_exc_deferred = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check16("R1 reset word", rd_data, 16'h0000);
      check1("R1 reset irq", irq, 1'b0);

      // Table walk: R1 R5 R6 R7 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         report(VEC[i][23:19], VEC[i][18], VEC[i][17], VEC[i][16]);
         check16($sformatf("R5 R6 R7 R8 vector %0d", i), rd_data, VEC[i][15:0]);
      end
      check1("R3 irq low below max", irq, 1'b0);

      // R9 idle holds
      repeat (3) @(negedge clk);
      check16("R9 idle stable", rd_data, 16'h2332);

      // R4 plain read
      @(negedge clk);
      rd_stb = 1'b1;
      #2;
      check16("R4 pre-clear value", rd_data, 16'h2332);
      @(negedge clk);
      rd_stb = 1'b0;
      check16("R4 cleared", rd_data, 16'h0000);

      // R2 R3 saturation of single field
      for (int n = 0; n < 14; n++) report(5'd1, 1'b1, 1'b0, 1'b0);
      check16("R2 count 14", rd_data, 16'h000E);
      check1("R3 irq low at 14", irq, 1'b0);
      report(5'd1, 1'b1, 1'b0, 1'b0);
      check16("R2 count 15", rd_data, 16'h000F);
      check1("R3 irq high at 15", irq, 1'b1);
      for (int n = 0; n < 5; n++) report(5'd1, 1'b1, 1'b0, 1'b0);
      check16("R2 no wrap", rd_data, 16'h000F);
      check1("R3 irq stays high", irq, 1'b1);

      // R10 read and report in the same cycle
      @(negedge clk);
      rd_stb = 1'b1; pkt_done = 1'b1; pkt_coll_cnt = 5'd1; pkt_ok = 1'b1; pkt_deferred = 1'b1;
      #2;
      check16("R10 pre-clear value", rd_data, 16'h000F);
      @(negedge clk);
      rd_stb = 1'b0; pkt_done = 1'b0; pkt_coll_cnt = '0; pkt_ok = 1'b0; pkt_deferred = 1'b0;
      check16("R10 restart at one", rd_data, 16'h0101);
      check1("R3 irq low after read", irq, 1'b0);

      finish_run();
   end

endmodule